// File: doc/BRIEF.md
# GPIO Port with Peripheral Pin Override

This block is an eight-pin general-purpose I/O port whose pins can be borrowed by on-chip peripherals. Software sets a direction register and a port register. The port register value is driven on pins configured as outputs. On pins configured as inputs it enables the pull-up. A synchronized pin-read register returns the pad levels.

Every pin also has an override record with four enable/value pairs: pull-up, direction, output value and digital input enable. Two peripherals fill these records. A serial peripheral interface owns the upper four pins: serial clock, master-in/slave-out, master-out/slave-in and slave select. Its role (master or slave) decides which of those pins are forced to input and which are driven. An external-memory interface time-multiplexes address and data on the low pins. When it is enabled, its address strobe and write strobe decide whether those pins drive and what they drive.

All override paths are combinational. A change in a peripheral control therefore reaches the pads in the same cycle. Raw pad levels are returned to both peripherals.

Top module: `gpio_ovr_port`

## Requirements
- R1: While reset is asserted, and after its release before any register write, the direction and port registers are 0, so pad_oe, pad_out, pad_pu and pin_rd are all 0.
- R2: A clock edge with dir_we high loads reg_wdata into the direction register, and one with out_we high loads it into the port register. On a pin with no active override, pad_oe equals its direction bit and pad_out equals its port bit.
- R3: pad_pu of a pin is 1 only when pad_oe of that pin is 0, pud is 0, and the pull-up source is 1. The pull-up source is the override value while the pull-up override is enabled, and the port bit otherwise.
- R4: pin_rd returns pad_in through two flops: a pad change made between edges appears on pin_rd after the second following rising edge, not after the first.
- R5: With spi_en=1 and spi_master=0, pins 7 (clock), 5 (master-out) and 4 (select) are inputs whatever the direction bits say. Their pull-ups still follow their port bits.
- R6: With spi_en=1 and spi_master=1, the directions of pins 7, 5 and 4 follow the direction bits. Pin 7 outputs spi_sck_out and pin 5 outputs spi_mosi_out.
- R7: Pin 6 (master-in) is an input whenever spi_en=1 and spi_master=1. With spi_en=1 and spi_master=0, its direction follows its direction bit and it outputs spi_miso_out.
- R8: With xmem_en=0, pins 3..0 behave as plain GPIO, whatever xmem_ale and xmem_wr say.
- R9: With xmem_en=1 and xmem_ale=1, pins 3..0 are outputs carrying xmem_addr (bit i on pin i), with their pull-ups off.
- R10: With xmem_en=1 and xmem_wr=1, pins 3..0 are outputs carrying xmem_wdata. If both strobes are high, the value is the bitwise OR of address and data.
- R11: With xmem_en=1 and both strobes low, pins 3..0 are inputs whatever their direction bits. Their pull-ups equal the port bits gated by pud.
- R12: spi_sck_in, spi_miso_in, spi_mosi_in and spi_ss_in equal pad_in[7], pad_in[6], pad_in[5] and pad_in[4], and xmem_rdata equals pad_in[3:0], all combinationally.
- R13: A change of any peripheral enable, role or strobe changes pad_oe, pad_out and pad_pu without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wdata | input | 8 | Register write data |
| dir_we | input | 1 | Write strobe for the direction register |
| out_we | input | 1 | Write strobe for the port register |
| pud | input | 1 | Global pull-up disable |
| spi_en | input | 1 | Serial interface enable |
| spi_master | input | 1 | Serial interface role, 1 = master |
| spi_sck_out | input | 1 | Serial clock to drive as master |
| spi_mosi_out | input | 1 | Master data to drive as master |
| spi_miso_out | input | 1 | Slave data to drive as slave |
| xmem_en | input | 1 | External-memory interface enable |
| xmem_ale | input | 1 | Address-phase strobe |
| xmem_wr | input | 1 | Write strobe |
| xmem_addr | input | 4 | Address bits for the low pins |
| xmem_wdata | input | 4 | Write data for the low pins |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad drive value |
| pad_oe | output | 8 | Pad output enable |
| pad_pu | output | 8 | Pad pull-up enable |
| pin_rd | output | 8 | Synchronized pin-read register |
| spi_sck_in | output | 1 | Clock pin level to the serial interface |
| spi_miso_in | output | 1 | Master-in pin level to the serial interface |
| spi_mosi_in | output | 1 | Master-out pin level to the serial interface |
| spi_ss_in | output | 1 | Select pin level to the serial interface |
| xmem_rdata | output | 4 | Low pin levels to the memory interface |

## Verification
The bench sets every direction bit to output and then turns on the serial slave role, checking that the clock, master-out and select pins go to input while the master-in pin keeps driving. A design that swapped the two roles' lists would leave the clock driving against an external master. The bench checks the pull-ups of the forced pins both from the port bits and under pud, since a design that took the pull-up from the direction override would lose them. For the memory pins, the bench raises both strobes together to expect the OR of address and data. It drops the strobe with no clock edge, to catch a registered override. It also counts the two edges of pin-read latency, so a one-flop or three-flop synchronizer fails.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;

  // Per-pin override record: enable/value pairs.
  typedef struct packed {
    logic pue;  // pull-up override enable
    logic puv;  // pull-up override value
    logic dde;  // direction override enable
    logic ddv;  // direction override value (1 = output)
    logic pve;  // output value override enable
    logic pvv;  // output value override value
    logic die;  // input enable override enable
    logic div;  // input enable override value
  } ovr_t;

  localparam ovr_t OVR_NONE = '0;

  function automatic logic pick(input logic en, input logic ov, input logic rv);
    return en ? ov : rv;
  endfunction

  function automatic logic pull_en(input logic oe, input logic src, input logic dis);
    return ~oe & src & ~dis;
  endfunction

  // Pin driven by the master (clock, master-out): input as slave, driven as master.
  function automatic ovr_t lead_ovr(input logic en, input logic master, input logic drv);
    ovr_t o = OVR_NONE;
    if (en && !master) begin
      o.dde = 1'b1;
      o.ddv = 1'b0;
    end
    if (en && master) begin
      o.pve = 1'b1;
      o.pvv = drv;
    end
    return o;
  endfunction

  // Master-in pin: input as master, slave drives its value.
  function automatic ovr_t follow_ovr(input logic en, input logic master, input logic drv);
    ovr_t o = OVR_NONE;
    if (en && master) begin
      o.dde = 1'b1;
      o.ddv = 1'b0;
    end
    if (en && !master) begin
      o.pve = 1'b1;
      o.pvv = drv;
    end
    return o;
  endfunction

  // Select pin: input while slave.
  function automatic ovr_t select_ovr(input logic en, input logic master);
    ovr_t o = OVR_NONE;
    if (en && !master) begin
      o.dde = 1'b1;
      o.ddv = 1'b0;
    end
    return o;
  endfunction

  // Multiplexed memory pin.
  function automatic ovr_t mem_ovr(input logic en, input logic ale, input logic wr,
                                   input logic a, input logic d, input logic port);
    ovr_t o = OVR_NONE;
    o.pue = en;
    o.puv = port & ~(ale | wr);
    o.dde = en;
    o.ddv = ale | wr;
    o.pve = en;
    o.pvv = (a & ale) | (d & wr);
    return o;
  endfunction

endpackage

// File: rtl/gpio_ovr_src.sv
module gpio_ovr_src
  import gpio_ovr_pkg::*;
#(
  parameter int W        = 8,
  parameter int NMEM     = 4,
  parameter int SCK_PIN  = 7,
  parameter int MISO_PIN = 6,
  parameter int MOSI_PIN = 5,
  parameter int SS_PIN   = 4
) (
  input  logic            spi_en,
  input  logic            spi_master,
  input  logic            spi_sck_out,
  input  logic            spi_mosi_out,
  input  logic            spi_miso_out,
  input  logic            xmem_en,
  input  logic            xmem_ale,
  input  logic            xmem_wr,
  input  logic [NMEM-1:0] xmem_addr,
  input  logic [NMEM-1:0] xmem_wdata,
  input  logic [W-1:0]    out_q,
  output ovr_t [W-1:0]    ovr
);

  for (genvar i = 0; i < W; i++) begin : g_pin
    if (i == SCK_PIN) begin : g_sck
      always_comb ovr[i] = lead_ovr(spi_en, spi_master, spi_sck_out);
    end else if (i == MOSI_PIN) begin : g_mosi
      always_comb ovr[i] = lead_ovr(spi_en, spi_master, spi_mosi_out);
    end else if (i == MISO_PIN) begin : g_miso
      always_comb ovr[i] = follow_ovr(spi_en, spi_master, spi_miso_out);
    end else if (i == SS_PIN) begin : g_ss
      always_comb ovr[i] = select_ovr(spi_en, spi_master);
    end else if (i < NMEM) begin : g_mem
      always_comb ovr[i] = mem_ovr(xmem_en, xmem_ale, xmem_wr,
                                   xmem_addr[i], xmem_wdata[i], out_q[i]);
    end else begin : g_plain
      always_comb ovr[i] = OVR_NONE;
    end
  end

endmodule

// File: rtl/gpio_ovr_pin.sv
module gpio_ovr_pin
  import gpio_ovr_pkg::*;
(
  input  ovr_t o,
  input  logic dir_b,
  input  logic out_b,
  input  logic pud,
  input  logic pad_in_b,
  output logic oe,
  output logic val,
  output logic pu,
  output logic din
);

  logic pu_src;

  always_comb begin
    oe     = pick(o.dde, o.ddv, dir_b);
    val    = pick(o.pve, o.pvv, out_b);
    pu_src = pick(o.pue, o.puv, out_b);
    pu     = pull_en(oe, pu_src, pud);
    din    = pad_in_b & pick(o.die, o.div, 1'b1);
  end

endmodule

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) st[k] <= '0;
    end else begin
      st[0] <= d;
      for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
    end
  end

  assign q = st[STAGES-1];

endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int W           = 8,
  parameter int NMEM        = 4,
  parameter int SCK_PIN     = 7,
  parameter int MISO_PIN    = 6,
  parameter int MOSI_PIN    = 5,
  parameter int SS_PIN      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    reg_wdata,
  input  logic            dir_we,
  input  logic            out_we,
  input  logic            pud,
  input  logic            spi_en,
  input  logic            spi_master,
  input  logic            spi_sck_out,
  input  logic            spi_mosi_out,
  input  logic            spi_miso_out,
  input  logic            xmem_en,
  input  logic            xmem_ale,
  input  logic            xmem_wr,
  input  logic [NMEM-1:0] xmem_addr,
  input  logic [NMEM-1:0] xmem_wdata,
  input  logic [W-1:0]    pad_in,
  output logic [W-1:0]    pad_out,
  output logic [W-1:0]    pad_oe,
  output logic [W-1:0]    pad_pu,
  output logic [W-1:0]    pin_rd,
  output logic            spi_sck_in,
  output logic            spi_miso_in,
  output logic            spi_mosi_in,
  output logic            spi_ss_in,
  output logic [NMEM-1:0] xmem_rdata
);

  logic [W-1:0] dir_q;
  logic [W-1:0] out_q;
  logic [W-1:0] din;
  ovr_t [W-1:0] ovr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      if (dir_we) dir_q <= reg_wdata;
      if (out_we) out_q <= reg_wdata;
    end
  end

  gpio_ovr_src #(
    .W(W), .NMEM(NMEM), .SCK_PIN(SCK_PIN), .MISO_PIN(MISO_PIN),
    .MOSI_PIN(MOSI_PIN), .SS_PIN(SS_PIN)
  ) u_src (
    .spi_en       (spi_en),
    .spi_master   (spi_master),
    .spi_sck_out  (spi_sck_out),
    .spi_mosi_out (spi_mosi_out),
    .spi_miso_out (spi_miso_out),
    .xmem_en      (xmem_en),
    .xmem_ale     (xmem_ale),
    .xmem_wr      (xmem_wr),
    .xmem_addr    (xmem_addr),
    .xmem_wdata   (xmem_wdata),
    .out_q        (out_q),
    .ovr          (ovr)
  );

  for (genvar i = 0; i < W; i++) begin : g_pin
    gpio_ovr_pin u_pin (
      .o        (ovr[i]),
      .dir_b    (dir_q[i]),
      .out_b    (out_q[i]),
      .pud      (pud),
      .pad_in_b (pad_in[i]),
      .oe       (pad_oe[i]),
      .val      (pad_out[i]),
      .pu       (pad_pu[i]),
      .din      (din[i])
    );
  end

  gpio_ovr_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (din),
    .q     (pin_rd)
  );

  assign spi_sck_in  = pad_in[SCK_PIN];
  assign spi_miso_in = pad_in[MISO_PIN];
  assign spi_mosi_in = pad_in[MOSI_PIN];
  assign spi_ss_in   = pad_in[SS_PIN];
  assign xmem_rdata  = pad_in[NMEM-1:0];

endmodule

// File: rtl/gpio_ovr_port_chk.sv
module gpio_ovr_port_chk #(
  parameter int W           = 8,
  parameter int NMEM        = 4,
  parameter int SCK_PIN     = 7,
  parameter int MISO_PIN    = 6,
  parameter int SYNC_STAGES = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pud,
  input logic            spi_en,
  input logic            spi_master,
  input logic            xmem_en,
  input logic            xmem_ale,
  input logic            xmem_wr,
  input logic [NMEM-1:0] xmem_addr,
  input logic [W-1:0]    dir_q,
  input logic [W-1:0]    out_q,
  input logic [W-1:0]    din,
  input logic [W-1:0]    pad_out,
  input logic [W-1:0]    pad_oe,
  input logic [W-1:0]    pad_pu,
  input logic [W-1:0]    pin_rd
);

  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  a_r3_no_pull_on_output: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);

  a_r3_global_disable: assert property (@(posedge clk) disable iff (!rst_n)
    pud |-> pad_pu == '0);

  if (SYNC_STAGES == 2) begin : g_sync_chk
    a_r4_two_flop_delay: assert property (@(posedge clk) disable iff (!rst_n)
      since_rst == 2'd2 |-> pin_rd == $past(din, 2));
  end

  a_r5_clock_slave_input: assert property (@(posedge clk) disable iff (!rst_n)
    spi_en && !spi_master |-> !pad_oe[SCK_PIN]);

  a_r5_forced_pull_from_port: assert property (@(posedge clk) disable iff (!rst_n)
    spi_en && !spi_master |-> pad_pu[SCK_PIN] == (out_q[SCK_PIN] && !pud));

  a_r6_clock_master_dir: assert property (@(posedge clk) disable iff (!rst_n)
    spi_en && spi_master |-> pad_oe[SCK_PIN] == dir_q[SCK_PIN]);

  a_r7_miso_master_input: assert property (@(posedge clk) disable iff (!rst_n)
    spi_en && spi_master |-> !pad_oe[MISO_PIN]);

  a_r9_address_drive: assert property (@(posedge clk) disable iff (!rst_n)
    xmem_en && xmem_ale && !xmem_wr |->
      (pad_oe[NMEM-1:0] == '1) && (pad_out[NMEM-1:0] == xmem_addr)
      && (pad_pu[NMEM-1:0] == '0));

  a_r11_idle_input: assert property (@(posedge clk) disable iff (!rst_n)
    xmem_en && !xmem_ale && !xmem_wr |-> pad_oe[NMEM-1:0] == '0);

endmodule

bind gpio_ovr_port gpio_ovr_port_chk #(
  .W(W), .NMEM(NMEM), .SCK_PIN(SCK_PIN), .MISO_PIN(MISO_PIN), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pud        (pud),
  .spi_en     (spi_en),
  .spi_master (spi_master),
  .xmem_en    (xmem_en),
  .xmem_ale   (xmem_ale),
  .xmem_wr    (xmem_wr),
  .xmem_addr  (xmem_addr),
  .dir_q      (dir_q),
  .out_q      (out_q),
  .din        (din),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .pad_pu     (pad_pu),
  .pin_rd     (pin_rd)
);

// File: tb/gpio_ovr_port_bench.sv
module gpio_ovr_port_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       dir_we = 1'b0, out_we = 1'b0, pud = 1'b0;
  logic       spi_en = 1'b0, spi_master = 1'b0;
  logic       spi_sck_out = 1'b0, spi_mosi_out = 1'b0, spi_miso_out = 1'b0;
  logic       xmem_en = 1'b0, xmem_ale = 1'b0, xmem_wr = 1'b0;
  logic [3:0] xmem_addr = '0, xmem_wdata = '0;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out, pad_oe, pad_pu, pin_rd;
  logic       spi_sck_in, spi_miso_in, spi_mosi_in, spi_ss_in;
  logic [3:0] xmem_rdata;

  int n_checks = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  gpio_ovr_port u_gpio_ovr_port (
    .clk(clk), .rst_n(rst_n), .reg_wdata(reg_wdata), .dir_we(dir_we), .out_we(out_we),
    .pud(pud), .spi_en(spi_en), .spi_master(spi_master), .spi_sck_out(spi_sck_out),
    .spi_mosi_out(spi_mosi_out), .spi_miso_out(spi_miso_out), .xmem_en(xmem_en),
    .xmem_ale(xmem_ale), .xmem_wr(xmem_wr), .xmem_addr(xmem_addr),
    .xmem_wdata(xmem_wdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .pin_rd(pin_rd), .spi_sck_in(spi_sck_in),
    .spi_miso_in(spi_miso_in), .spi_mosi_in(spi_mosi_in), .spi_ss_in(spi_ss_in),
    .xmem_rdata(xmem_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put_reg(input bit to_port, input logic [7:0] v);
    @(negedge clk);
    reg_wdata = v;
    dir_we = !to_port;
    out_we = to_port;
    @(negedge clk);
    dir_we = 1'b0;
    out_we = 1'b0;
    #1;
  endtask

  task automatic quiet();
    @(negedge clk);
    spi_en = 0; spi_master = 0; xmem_en = 0; xmem_ale = 0; xmem_wr = 0; pud = 0;
    #1;
  endtask

  task automatic t_reset();
    pad_in = 8'hFF;
    #7;
    chk("R1 pad_oe in reset", pad_oe, 8'h00);
    chk("R1 pad_pu in reset", pad_pu, 8'h00);
    chk("R1 pin_rd in reset", pin_rd, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    pad_in = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 pad_out after reset", pad_out, 8'h00);
    chk("R1 pad_oe after reset", pad_oe, 8'h00);
  endtask

  task automatic t_regs();
    put_reg(0, 8'hF0);
    put_reg(1, 8'hAA);
    chk("R2 pad_oe follows direction", pad_oe, 8'hF0);
    chk("R2 pad_out follows port", pad_out, 8'hAA);
  endtask

  task automatic t_pullup();
    put_reg(0, 8'h0F);
    put_reg(1, 8'hFF);
    chk("R3 pull-up on inputs", pad_pu, 8'hF0);
    @(negedge clk); pud = 1'b1; #1;
    chk("R3 pull-up under pud", pad_pu, 8'h00);
    @(negedge clk); pud = 1'b0; #1;
  endtask

  task automatic t_sync();
    put_reg(0, 8'h00);
    @(negedge clk); pad_in = 8'h00;
    repeat (3) @(negedge clk);
    pad_in = 8'h5A;
    @(posedge clk); #1;
    chk("R4 pin_rd after one edge", pin_rd, 8'h00);
    @(posedge clk); #1;
    chk("R4 pin_rd after two edges", pin_rd, 8'h5A);
  endtask

  task automatic t_spi_slave();
    put_reg(0, 8'hFF);
    put_reg(1, 8'hB0);
    @(negedge clk);
    spi_en = 1; spi_master = 0; spi_miso_out = 1;
    #1;
    chk("R5 slave forces clock/mosi/select input", pad_oe[7:4], 4'h4);
    chk("R5 forced pins pull-up from port", pad_pu[7:4], 4'hB);
    chk("R7 slave drives miso_out", pad_out[6], 1'b1);
    @(negedge clk); pud = 1; #1;
    chk("R5 forced pins pull-up gated by pud", pad_pu[7:4], 4'h0);
    quiet();
    chk("R13 disable releases pins same cycle", pad_oe[7:4], 4'hF);
  endtask

  task automatic t_spi_master();
    put_reg(0, 8'hE0);
    put_reg(1, 8'h00);
    @(negedge clk);
    spi_en = 1; spi_master = 1; spi_sck_out = 1; spi_mosi_out = 1; spi_miso_out = 1;
    #1;
    chk("R7 master forces miso input", pad_oe[6], 1'b0);
    chk("R6 master direction from register", pad_oe[7:4], 4'hA);
    chk("R6 master drives clock and mosi", pad_out[7:4], 4'hA);
    @(negedge clk); spi_sck_out = 0; #1;
    chk("R6 clock value tracks peripheral", pad_out[7], 1'b0);
    put_reg(0, 8'h00);
    chk("R6 clock direction bit cleared", pad_oe[7], 1'b0);
    quiet();
  endtask

  task automatic t_returns();
    @(negedge clk); pad_in = 8'h90; #1;
    chk("R12 returns for 0x90",
        {spi_sck_in, spi_miso_in, spi_mosi_in, spi_ss_in, xmem_rdata}, 8'h90);
    @(negedge clk); pad_in = 8'h65; #1;
    chk("R12 returns for 0x65",
        {spi_sck_in, spi_miso_in, spi_mosi_in, spi_ss_in, xmem_rdata}, 8'h65);
    pad_in = 8'h00;
  endtask

  task automatic t_mem();
    put_reg(0, 8'h0C);
    put_reg(1, 8'h0A);
    @(negedge clk); xmem_en = 0; xmem_ale = 1; xmem_addr = 4'h5; #1;
    chk("R8 disabled: direction from register", pad_oe[3:0], 4'hC);
    chk("R8 disabled: value from port", pad_out[3:0], 4'hA);
    chk("R8 disabled: pull-up from port", pad_pu[3:0], 4'h2);
    @(negedge clk); xmem_en = 1; #1;
    chk("R9 address phase drives", pad_oe[3:0], 4'hF);
    chk("R9 address on pins", pad_out[3:0], 4'h5);
    chk("R9 address phase pull-up off", pad_pu[3:0], 4'h0);
    @(negedge clk); xmem_ale = 0; xmem_wr = 1; xmem_wdata = 4'h3; #1;
    chk("R10 write data on pins", pad_out[3:0], 4'h3);
    chk("R10 write phase drives", pad_oe[3:0], 4'hF);
    @(negedge clk); xmem_ale = 1; #1;
    chk("R10 both strobes OR", pad_out[3:0], 4'h7);
    @(negedge clk); xmem_ale = 0; xmem_wr = 0; #1;
    chk("R11 idle forces input", pad_oe[3:0], 4'h0);
    chk("R11 idle pull-up from port", pad_pu[3:0], 4'hA);
    xmem_ale = 1; #1;
    chk("R13 strobe acts without clock", pad_oe[3:0], 4'hF);
    quiet();
  endtask

  initial begin
    #400000;
    n_err++;
    $display("FAIL watchdog all requirements actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_regs();
    t_pullup();
    t_sync();
    t_spi_slave();
    t_spi_master();
    t_returns();
    t_mem();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule